// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translator with sixteen entries. Each entry describes two neighbouring virtual pages, an even one and an odd one. The entry holds one virtual tag, a per-entry page-size mask, an address-space identifier, a global flag and a hardware-invalidate flag. Each of the two halves has its own physical frame number and its own valid, dirty, read-inhibit and execute-inhibit bits. A requester presents a virtual address, an access kind and the current address-space identifier with a one-cycle strobe. One clock later the block returns a result code, a physical address and a write-permission flag. A separate write port replaces a whole entry in one cycle, which also covers invalidation.

The control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_RESULT` means the registered outputs hold the answer to the strobe of the previous cycle. The transition `idle_to_result` is taken on a strobe from `ST_IDLE`. `result_hold` is taken on a strobe from `ST_RESULT`, for back-to-back lookups. `result_to_idle` is taken from `ST_RESULT` when there is no strobe. With no strobe in `ST_IDLE` the machine stays in `idle_wait`.

Top module: `tlb_pair_lookup`

## Requirements
- R1: Synchronous reset (`rst` high) marks every entry hardware-invalidated and drops `rsp_valid`. A lookup after reset returns no-match (code 1) until an entry is written.
- R2: A lookup strobe `req` in cycle N gives `rsp_valid` high in cycle N+1 and at no other time. Back-to-back strobes give back-to-back results.
- R3: An entry hits only when all three of these hold: its hardware-invalidate flag is clear; its global flag is set or its identifier equals `req_asid`; and its tag equals the address on every bit that the effective mask leaves clear.
- R4: The effective mask is the entry page mask ORed with ones in bits 12:0. The highest set bit of the effective mask picks the half. A 0 picks the even frame and flags (vector bit 0), and a 1 picks the odd frame and flags (vector bit 1).
- R5: On a match, `rsp_paddr` equals the selected 20-bit frame number shifted left by 12, ORed with the address bits under the effective mask shifted right by one. On any other code, `rsp_paddr` is 0 and `rsp_wr_ok` is 0.
- R6: Checks on a hit run in a fixed order. First, a clear valid bit on the selected half gives invalid (code 2) for every access kind. The later checks then follow, and the result is match (code 0) when none of them fires.
- R7: After the valid check, a fetch (`req_acc`=0) whose selected execute-inhibit bit is set gives execute-inhibit (code 5). A load (`req_acc`=1, and 3, which is treated as a load) whose selected read-inhibit bit is set gives read-inhibit (code 4). Other access kinds ignore these bits.
- R8: A store (`req_acc`=2) whose selected dirty bit is clear gives modified (code 3). On a match, `rsp_wr_ok` equals the selected dirty bit.
- R9: When several entries hit, the entry with the lowest index decides the result.
- R10: When no entry hits, the code is no-match (code 1).
- R11: `wr_en` writes all fields into entry `wr_idx` at the clock edge. A lookup in that same cycle sees the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Lookup strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| req_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Result presented this cycle |
| rsp_code | output | 3 | 0 match, 1 no-match, 2 invalid, 3 modified, 4 read-inhibit, 5 execute-inhibit |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_wr_ok | output | 1 | Write permission on a match |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 32 | Virtual tag (bits under the mask ignored) |
| wr_pmask | input | 32 | Page mask, contiguous ones from bit 13 upward |
| wr_asid | input | 8 | Entry address-space identifier |
| wr_global | input | 1 | Entry matches any identifier |
| wr_hinv | input | 1 | Hardware-invalidate flag |
| wr_pfn0 | input | 20 | Even-half frame number |
| wr_pfn1 | input | 20 | Odd-half frame number |
| wr_valid | input | 2 | Valid bits, bit 0 even, bit 1 odd |
| wr_dirty | input | 2 | Dirty bits, bit 0 even, bit 1 odd |
| wr_rdinh | input | 2 | Read-inhibit bits, bit 0 even, bit 1 odd |
| wr_exinh | input | 2 | Execute-inhibit bits, bit 0 even, bit 1 odd |

## Verification
The bound checker tests, on every cycle, the invariants that hold at the ports whatever the table holds. These are the one-cycle strobe-to-result timing, that only legal codes appear, and that write permission and a non-zero address appear only on a match. It also checks that a fetch never reports read-inhibit or modified, and that a store match always grants write permission. The invariants cannot show that the translation itself is right: the hit rule, the half selection under large page masks, the fault ordering, lowest-index priority and the old-contents view during a same-cycle write. The bench shows these by comparing every cycle against its behavioural table model, over directed and random lookups.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
    localparam int VA_W       = 32;
    localparam int ASID_W     = 8;
    localparam int PFN_W      = 20;
    localparam int PAGE_SHIFT = 12;
    localparam int PAIR_BITS  = PAGE_SHIFT + 1;
    localparam int PA_W       = PFN_W + PAGE_SHIFT;
    localparam logic [VA_W-1:0] MIN_MASK = (VA_W'(1) << PAIR_BITS) - VA_W'(1);

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALTLD = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        RES_MATCH    = 3'd0,
        RES_NOMATCH  = 3'd1,
        RES_INVALID  = 3'd2,
        RES_MODIFIED = 3'd3,
        RES_RDINH    = 3'd4,
        RES_EXINH    = 3'd5
    } res_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } fsm_e;

    typedef struct packed {
        logic [VA_W-1:0]   vpn;
        logic [VA_W-1:0]   pmask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              hinv;
        logic [PFN_W-1:0]  pfn0;
        logic [PFN_W-1:0]  pfn1;
        logic [1:0]        valid;
        logic [1:0]        dirty;
        logic [1:0]        rdinh;
        logic [1:0]        exinh;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pair_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_data,
    output tlb_entry_t       ents [N_ENT]
);
    tlb_entry_t store_q [N_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) begin
                store_q[i]      <= '0;
                store_q[i].hinv <= 1'b1;
            end
        end else if (wr_en) begin
            store_q[wr_idx] <= wr_data;
        end
    end

    assign ents = store_q;
endmodule

// File: rtl/tlb_match_unit.sv
module tlb_match_unit
    import tlb_pair_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    input  tlb_entry_t        ents [N_ENT],
    output logic [N_ENT-1:0]  hit,
    output logic [N_ENT-1:0]  half
);
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic [VA_W-1:0] eff_mask;
        logic            id_ok;
        logic            tag_ok;
        assign eff_mask = ents[g].pmask | MIN_MASK;
        assign id_ok    = ents[g].glob || (ents[g].asid == asid);
        assign tag_ok   = (va & ~eff_mask) == (ents[g].vpn & ~eff_mask);
        assign hit[g]   = id_ok && tag_ok && !ents[g].hinv;
        assign half[g]  = |(va & eff_mask & ~(eff_mask >> 1));
    end
endmodule

// File: rtl/tlb_result_select.sv
module tlb_result_select
    import tlb_pair_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [VA_W-1:0]  va,
    input  logic [1:0]       acc,
    input  tlb_entry_t       ents [N_ENT],
    input  logic [N_ENT-1:0] hit,
    input  logic [N_ENT-1:0] half,
    output logic [2:0]       code,
    output logic [PA_W-1:0]  paddr,
    output logic             wr_ok
);
    logic             found;
    logic [IDX_W-1:0] sel;
    tlb_entry_t       e;
    logic [VA_W-1:0]  eff_mask;
    logic [VA_W-1:0]  offs;
    logic             n;
    logic [PFN_W-1:0] pfn;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!found && hit[i]) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        e        = ents[sel];
        n        = half[sel];
        eff_mask = e.pmask | MIN_MASK;
        offs     = va & (eff_mask >> 1);
        pfn      = n ? e.pfn1 : e.pfn0;
        code     = RES_NOMATCH;
        paddr    = '0;
        wr_ok    = 1'b0;
        if (found) begin
            if (!e.valid[n]) begin
                code = RES_INVALID;
            end else if (acc == ACC_FETCH && e.exinh[n]) begin
                code = RES_EXINH;
            end else if ((acc == ACC_LOAD || acc == ACC_ALTLD) && e.rdinh[n]) begin
                code = RES_RDINH;
            end else if (acc == ACC_STORE && !e.dirty[n]) begin
                code = RES_MODIFIED;
            end else begin
                code  = RES_MATCH;
                paddr = {pfn, {PAGE_SHIFT{1'b0}}} | PA_W'(offs);
                wr_ok = e.dirty[n];
            end
        end
    end
endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
    import tlb_pair_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [ASID_W-1:0] req_asid,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_wr_ok,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_vpn,
    input  logic [VA_W-1:0]   wr_pmask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic              wr_hinv,
    input  logic [PFN_W-1:0]  wr_pfn0,
    input  logic [PFN_W-1:0]  wr_pfn1,
    input  logic [1:0]        wr_valid,
    input  logic [1:0]        wr_dirty,
    input  logic [1:0]        wr_rdinh,
    input  logic [1:0]        wr_exinh
);
    fsm_e             state_q, state_d;
    tlb_entry_t       wr_data;
    tlb_entry_t       ents [N_ENT];
    logic [N_ENT-1:0] hit, half;
    logic [2:0]       code_c;
    logic [PA_W-1:0]  paddr_c;
    logic             wr_ok_c;
    logic [2:0]       code_q;
    logic [PA_W-1:0]  paddr_q;
    logic             wr_ok_q;

    always_comb begin
        wr_data.vpn   = wr_vpn;
        wr_data.pmask = wr_pmask;
        wr_data.asid  = wr_asid;
        wr_data.glob  = wr_global;
        wr_data.hinv  = wr_hinv;
        wr_data.pfn0  = wr_pfn0;
        wr_data.pfn1  = wr_pfn1;
        wr_data.valid = wr_valid;
        wr_data.dirty = wr_dirty;
        wr_data.rdinh = wr_rdinh;
        wr_data.exinh = wr_exinh;
    end

    tlb_entry_store #(.N_ENT(N_ENT)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .ents(ents)
    );

    tlb_match_unit #(.N_ENT(N_ENT)) u_match (
        .va(req_vaddr), .asid(req_asid), .ents(ents), .hit(hit), .half(half)
    );

    tlb_result_select #(.N_ENT(N_ENT)) u_select (
        .va(req_vaddr), .acc(req_acc), .ents(ents), .hit(hit), .half(half),
        .code(code_c), .paddr(paddr_c), .wr_ok(wr_ok_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // result capture
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= RES_NOMATCH;
            paddr_q <= '0;
            wr_ok_q <= 1'b0;
        end else if (req) begin
            code_q  <= code_c;
            paddr_q <= paddr_c;
            wr_ok_q <= wr_ok_c;
        end
    end

    // outputs
    always_comb begin
        rsp_valid = (state_q == ST_RESULT);
        rsp_code  = code_q;
        rsp_paddr = paddr_q;
        rsp_wr_ok = wr_ok_q;
    end
endmodule

// File: rtl/tlb_lookup_checker.sv
module tlb_lookup_checker
    import tlb_pair_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req,
    input logic [1:0]      req_acc,
    input logic            rsp_valid,
    input logic [2:0]      rsp_code,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_wr_ok
);
    assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (rst)
        req |=> rsp_valid);
    assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (rst)
        !req |=> !rsp_valid);
    assert_legal_code_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_code <= 3'd5));
    assert_miss_no_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 3'd0) |-> (rsp_paddr == '0 && !rsp_wr_ok));
    assert_wr_ok_only_match_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_wr_ok) |-> (rsp_code == 3'd0));
    assert_store_match_writable_R8: assert property (@(posedge clk) disable iff (rst)
        (req && req_acc == 2'd2) |=> (rsp_code != 3'd0 || rsp_wr_ok));
    assert_fetch_codes_R7: assert property (@(posedge clk) disable iff (rst)
        (req && req_acc == 2'd0) |=> (rsp_code != 3'd4 && rsp_code != 3'd3));
endmodule

bind tlb_pair_lookup tlb_lookup_checker u_chk (
    .clk(clk), .rst(rst), .req(req), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .rsp_wr_ok(rsp_wr_ok)
);

// File: tb/test_tlb_pair_lookup.sv
`timescale 1ns/1ps
module test_tlb_pair_lookup;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [7:0]  req_asid = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_code;
    logic [31:0] rsp_paddr;
    logic        rsp_wr_ok;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_vpn = '0, wr_pmask = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0, wr_hinv = 1'b0;
    logic [19:0] wr_pfn0 = '0, wr_pfn1 = '0;
    logic [1:0]  wr_valid = '0, wr_dirty = '0, wr_rdinh = '0, wr_exinh = '0;

    int compared = 0;
    int mismatched = 0;

    // behavioural table model
    logic [31:0] m_vpn [16];
    logic [31:0] m_pmask [16];
    logic [7:0]  m_asid [16];
    bit          m_g [16];
    bit          m_hinv [16];
    logic [19:0] m_pfn [16][2];
    logic [1:0]  m_v [16], m_d [16], m_ri [16], m_xi [16];

    bit          exp_v = 0;
    logic [2:0]  exp_code;
    logic [31:0] exp_pa;
    bit          exp_wok;

    tlb_pair_lookup i_tlb_pair_lookup (
        .clk(clk), .rst(rst), .req(req), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .req_asid(req_asid), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_paddr(rsp_paddr), .rsp_wr_ok(rsp_wr_ok), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_pmask(wr_pmask), .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_hinv(wr_hinv), .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1), .wr_valid(wr_valid),
        .wr_dirty(wr_dirty), .wr_rdinh(wr_rdinh), .wr_exinh(wr_exinh)
    );

    always #4 clk = ~clk;

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_vpn[i] = 0; m_pmask[i] = 0; m_asid[i] = 0; m_g[i] = 0; m_hinv[i] = 1;
            m_pfn[i][0] = 0; m_pfn[i][1] = 0;
            m_v[i] = 0; m_d[i] = 0; m_ri[i] = 0; m_xi[i] = 0;
        end
    endtask

    task automatic ref_lookup(input logic [31:0] va, input logic [1:0] acc,
                              input logic [7:0] asid);
        logic [31:0] mask;
        int h;
        exp_code = 3'd1; exp_pa = 0; exp_wok = 0;
        for (int i = 0; i < 16; i++) begin
            mask = m_pmask[i] | 32'h1FFF;
            if (!m_hinv[i] && (m_g[i] || m_asid[i] == asid) &&
                ((va & ~mask) == (m_vpn[i] & ~mask))) begin
                h = 0;
                for (int b = 31; b >= 0; b--) if (mask[b]) begin h = va[b]; break; end
                if (!m_v[i][h])                               exp_code = 3'd2;
                else if (acc == 0 && m_xi[i][h])              exp_code = 3'd5;
                else if ((acc == 1 || acc == 3) && m_ri[i][h]) exp_code = 3'd4;
                else if (acc == 2 && !m_d[i][h])              exp_code = 3'd3;
                else begin
                    exp_code = 3'd0;
                    exp_pa   = (32'(m_pfn[i][h]) * 4096) + (va % ((mask + 1) / 2));
                    exp_wok  = m_d[i][h];
                end
                break;
            end
        end
    endtask

    // one clock: predict, update model, advance, compare
    task automatic tick(input string tag);
        exp_v = req;
        if (req) ref_lookup(req_vaddr, req_acc, req_asid);
        if (rst) model_reset();
        else if (wr_en) begin
            m_vpn[wr_idx] = wr_vpn; m_pmask[wr_idx] = wr_pmask; m_asid[wr_idx] = wr_asid;
            m_g[wr_idx] = wr_global; m_hinv[wr_idx] = wr_hinv;
            m_pfn[wr_idx][0] = wr_pfn0; m_pfn[wr_idx][1] = wr_pfn1;
            m_v[wr_idx] = wr_valid; m_d[wr_idx] = wr_dirty;
            m_ri[wr_idx] = wr_rdinh; m_xi[wr_idx] = wr_exinh;
        end
        @(posedge clk);
        @(negedge clk);
        compared++;
        if (rst) begin
            if (rsp_valid !== 1'b0) begin
                mismatched++;
                $display("FAIL %s rsp_valid in reset act=%b exp=0", tag, rsp_valid);
            end
        end else if (rsp_valid !== exp_v ||
                     (exp_v && (rsp_code !== exp_code || rsp_paddr !== exp_pa ||
                                rsp_wr_ok !== exp_wok))) begin
            mismatched++;
            $display("FAIL %s act v=%b c=%0d pa=%h w=%b exp v=%b c=%0d pa=%h w=%b", tag,
                     rsp_valid, rsp_code, rsp_paddr, rsp_wr_ok, exp_v, exp_code, exp_pa, exp_wok);
        end
        req = 0; wr_en = 0;
    endtask

    // hand-computed check at the current sample point
    task automatic hand(input logic [2:0] c, input logic [31:0] pa, input bit w, input string tag);
        compared++;
        if (rsp_valid !== 1'b1 || rsp_code !== c || rsp_paddr !== pa || rsp_wr_ok !== w) begin
            mismatched++;
            $display("FAIL %s act v=%b c=%0d pa=%h w=%b exp v=1 c=%0d pa=%h w=%b", tag,
                     rsp_valid, rsp_code, rsp_paddr, rsp_wr_ok, c, pa, w);
        end
    endtask

    task automatic stage_write(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                               input logic [7:0] asid, input bit g, input bit hv,
                               input logic [19:0] p0, input logic [19:0] p1,
                               input logic [1:0] v, input logic [1:0] d,
                               input logic [1:0] ri, input logic [1:0] xi);
        wr_en = 1; wr_idx = 4'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = asid;
        wr_global = g; wr_hinv = hv; wr_pfn0 = p0; wr_pfn1 = p1;
        wr_valid = v; wr_dirty = d; wr_rdinh = ri; wr_exinh = xi;
    endtask

    task automatic stage_look(input logic [31:0] va, input logic [1:0] acc, input logic [7:0] asid);
        req = 1; req_vaddr = va; req_acc = acc; req_asid = asid;
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic [7:0] asid,
                        input string tag);
        stage_look(va, acc, asid);
        tick(tag);
    endtask

    initial begin
        #(8 * 200000);
        mismatched++;
        $display("FAIL R2 watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] bases [6];
        bases = '{32'h0040_0000, 32'h1000_0000, 32'h2000_0000,
                  32'h3000_0000, 32'h4000_0000, 32'h5000_0000};
        model_reset();
        @(negedge clk);
        repeat (3) tick("R1");
        rst = 0;
        tick("R1");
        // R1: empty table after reset
        look(32'h0040_0ABC, 2'd1, 8'd5, "R1");
        hand(3'd1, 32'h0, 0, "R1");
        look(32'h0000_0000, 2'd0, 8'd0, "R10");
        hand(3'd1, 32'h0, 0, "R10");
        // R3 R4 R5 R8: small-page entry
        stage_write(0, 32'h0040_0000, 32'h0, 8'd5, 0, 0, 20'h12345, 20'h54321,
                    2'b11, 2'b01, 2'b00, 2'b00);
        tick("R11");
        look(32'h0040_0ABC, 2'd1, 8'd5, "R5");
        hand(3'd0, 32'h1234_5ABC, 1, "R5");
        look(32'h0040_1ABC, 2'd2, 8'd5, "R8");
        hand(3'd3, 32'h0, 0, "R8");
        look(32'h0040_1ABC, 2'd1, 8'd5, "R4");
        hand(3'd0, 32'h5432_1ABC, 0, "R4");
        look(32'h0040_0ABC, 2'd1, 8'd6, "R3");
        hand(3'd1, 32'h0, 0, "R3");
        // R3 R4: global entry with 64 KB pages
        stage_write(1, 32'h1000_0000, 32'h0001_E000, 8'd0, 1, 0, 20'h80000, 20'h80010,
                    2'b11, 2'b11, 2'b00, 2'b00);
        tick("R11");
        look(32'h1000_5678, 2'd0, 8'd9, "R3");
        hand(3'd0, 32'h8000_5678, 1, "R3");
        look(32'h1001_2345, 2'd1, 8'd9, "R4");
        hand(3'd0, 32'h8001_2345, 1, "R4");
        look(32'h1002_0000, 2'd1, 8'd9, "R10");
        hand(3'd1, 32'h0, 0, "R10");
        // R6 R7 R8: inhibit ordering
        stage_write(2, 32'h2000_0000, 32'h0, 8'd5, 0, 0, 20'h22220, 20'h22221,
                    2'b11, 2'b00, 2'b10, 2'b01);
        tick("R11");
        look(32'h2000_0010, 2'd0, 8'd5, "R7");
        hand(3'd5, 32'h0, 0, "R7");
        look(32'h2000_0010, 2'd1, 8'd5, "R7");
        hand(3'd0, 32'h2222_0010, 0, "R7");
        look(32'h2000_1010, 2'd1, 8'd5, "R7");
        hand(3'd4, 32'h0, 0, "R7");
        look(32'h2000_1010, 2'd3, 8'd5, "R7");
        hand(3'd4, 32'h0, 0, "R7");
        look(32'h2000_1010, 2'd0, 8'd5, "R7");
        hand(3'd0, 32'h2222_1010, 0, "R7");
        look(32'h2000_0010, 2'd2, 8'd5, "R8");
        hand(3'd3, 32'h0, 0, "R8");
        stage_write(3, 32'h3000_0000, 32'h0, 8'd5, 0, 0, 20'h33330, 20'h33331,
                    2'b10, 2'b11, 2'b00, 2'b01);
        tick("R11");
        look(32'h3000_0000, 2'd0, 8'd5, "R6");
        hand(3'd2, 32'h0, 0, "R6");
        // R9: lowest index wins, then invalidate it
        stage_write(4, 32'h4000_0000, 32'h0, 8'd5, 0, 0, 20'h44444, 20'h44445,
                    2'b11, 2'b11, 2'b00, 2'b00);
        tick("R11");
        stage_write(5, 32'h4000_0000, 32'h0, 8'd5, 0, 0, 20'h55555, 20'h55556,
                    2'b11, 2'b11, 2'b00, 2'b00);
        tick("R11");
        look(32'h4000_0123, 2'd1, 8'd5, "R9");
        hand(3'd0, 32'h4444_4123, 1, "R9");
        stage_write(4, 32'h4000_0000, 32'h0, 8'd5, 0, 1, 20'h44444, 20'h44445,
                    2'b11, 2'b11, 2'b00, 2'b00);
        tick("R3");
        look(32'h4000_0123, 2'd1, 8'd5, "R9");
        hand(3'd0, 32'h5555_5123, 1, "R9");
        // R11: same-cycle write sees old contents
        stage_write(6, 32'h5000_0000, 32'h0, 8'd0, 1, 0, 20'h66666, 20'h66667,
                    2'b11, 2'b11, 2'b00, 2'b00);
        stage_look(32'h5000_0040, 2'd1, 8'd7);
        tick("R11");
        hand(3'd1, 32'h0, 0, "R11");
        look(32'h5000_0040, 2'd1, 8'd7, "R11");
        hand(3'd0, 32'h6666_6040, 1, "R11");
        // R2: idle gaps and back-to-back traffic, random lookups
        tick("R2");
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 4 != 0) begin
                logic [7:0] a;
                a = (($urandom % 3) == 0) ? 8'd9 : ((($urandom % 2) == 0) ? 8'd5 : 8'd6);
                stage_look(bases[$urandom % 6] + ($urandom & 32'h0003_FFFF),
                           2'($urandom % 4), a);
            end
            tick("R2");
        end
        // reset mid-run clears table again
        rst = 1;
        tick("R1");
        rst = 0;
        look(32'h0040_0ABC, 2'd1, 8'd5, "R1");
        hand(3'd1, 32'h0, 0, "R1");
        tick("R2");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule